// File: doc/BRIEF.md
# Packet FIFO Interrupt Status and Reset Controller

This block is the control slice of a memory-mapped packet FIFO peripheral. It keeps a 32-bit pending-event word and a 32-bit event-enable word, turns one-cycle event pulses from the transmit and receive paths into sticky status bits, and drives one level-sensitive interrupt line. A status bit is raised whether or not it is enabled. The enable word only decides which pending bits reach the interrupt line.

The block also decodes keyed reset commands for the transmit side, the receive side and the whole core. A reset starts only when its register is written with the exact key 0xA5. The block then holds the matching reset strobe for a programmable number of cycles. When a side finishes, the block posts a reset-complete event into the status word. Software talks to the block through a plain single-cycle write port and a read port with one cycle of latency.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset the status and enable words are zero, `irq_o`, `core_rst_o`, `tx_rst_o` and `rx_rst_o` are low, and `reg_rdata` is zero.
- R2: A pulse on `evt_i[k]` sets status bit 19+k at the next clock edge. This happens whatever the enable word holds. Bit meanings: 31 receive under-read, 30 receive over-read, 29 receive empty-read, 28 transmit overrun, 27 transmit done, 26 receive done, 25 transmit length mismatch, 22/21 transmit programmable full/empty, 20/19 receive programmable full/empty.
- R3: A write to byte offset 0x00 clears every status bit whose data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears all pending bits.
- R4: An event that arrives in the same cycle as a clear of its own bit leaves that bit set.
- R5: Only bits 31..19 exist. Bits 18..0 of the status and enable words always read zero. A write to offset 0x04 loads the enable word with the data masked to bits 31..19.
- R6: `irq_o` is high exactly when the status word AND the enable word is nonzero. It follows the register values after each edge.
- R7: Writing 0xA5 to offset 0x08 holds `tx_rst_o` high for RST_CYCLES cycles and then sets status bit 24. Writing 0xA5 to offset 0x18 does the same with `rx_rst_o` and bit 23.
- R8: A write of any value other than exactly 0x000000A5 to a reset offset starts no reset and changes nothing.
- R9: Writing 0xA5 to offset 0x28 starts both the transmit and receive resets. `core_rst_o` is high from then until the first reset-complete event, and both bits 24 and 23 are set.
- R10: `evt_i[5]` and `evt_i[4]` (positions 24 and 23) are ignored. Those bits are set only on reset completion.
- R11: A read issued at offset 0x00 or 0x04 returns that register's value of the issuing cycle on `reg_rdata` in the next cycle. A read of any other offset returns zero.
- R12: A keyed write to a side whose reset is still running restarts its count. The completion that would have fallen in that cycle is not posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Register read strobe |
| reg_raddr | input | ADDR_W | Read byte offset |
| reg_rdata | output | 32 | Read data, one cycle after `reg_re` |
| evt_i | input | 13 | Event pulses, bit k maps to status bit 19+k |
| irq_o | output | 1 | Level interrupt |
| core_rst_o | output | 1 | Core-wide reset in progress |
| tx_rst_o | output | 1 | Transmit-side reset strobe |
| rx_rst_o | output | 1 | Receive-side reset strobe |

## Verification
The bench targets same-cycle collisions:
- An event meeting a clear of its own bit. A design that lets the clear win would lose that event.
- A reset command landing on the final cycle of a running reset. A wrong design would post a stray completion or run out the old count.

It also drives keys that differ from 0xA5 only above bit 7. A design that compared just the low byte would then reset. Random event traffic under changing enables checks that the interrupt line follows status AND enable exactly. It also checks that positions 24 and 23 cannot be forced from the event inputs.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned EVT_LSB    = 19;
   localparam int unsigned EVT_NUM    = 13;
   localparam int unsigned BIT_TX_RDY = 24;
   localparam int unsigned BIT_RX_RDY = 23;
   localparam logic [REG_W-1:0] IMPL_MASK = 32'hFFF8_0000;
   localparam logic [REG_W-1:0] RST_KEY   = 32'h0000_00A5;
   localparam logic [7:0] OFF_STAT  = 8'h00;
   localparam logic [7:0] OFF_ENA   = 8'h04;
   localparam logic [7:0] OFF_TXRST = 8'h08;
   localparam logic [7:0] OFF_RXRST = 8'h18;
   localparam logic [7:0] OFF_CORE  = 8'h28;
   typedef enum logic [0:0] {SIDE_TX = 1'b0, SIDE_RX = 1'b1} side_e;
endpackage

// File: rtl/pirq_rst_seq.sv
module pirq_rst_seq #(
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

   generate
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy = busy_q;
   assign last = busy_q && (cnt_q == '0);

   assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (start && last) |=> (busy && !last || RST_CYCLES == 1));
   assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start) |=> !busy);
endmodule

// File: rtl/pirq_status.sv
module pirq_status #(
   parameter int unsigned REG_W = 32,
   parameter logic [REG_W-1:0] MASK = 32'hFFF8_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_vec,
   input  logic [REG_W-1:0] clr_vec,
   input  logic             ena_we,
   input  logic [REG_W-1:0] ena_wdata,
   output logic [REG_W-1:0] stat,
   output logic [REG_W-1:0] ena,
   output logic             irq
);
   logic [REG_W-1:0] stat_q, ena_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         ena_q  <= '0;
      end else begin
         stat_q <= ((stat_q & ~clr_vec) | set_vec) & MASK;
         if (ena_we) ena_q <= ena_wdata & MASK;
      end
   end

   assign stat = stat_q;
   assign ena  = ena_q;
   assign irq  = |(stat_q & ena_q);

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & MASK) != '0) |=> ((stat & $past(set_vec & MASK)) == $past(set_vec & MASK)));
   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0) |=> ((stat & $past(clr_vec & ~set_vec)) == '0));
   assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat | ena) & ~MASK) == '0);
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
   import pirq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_re,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [31:0]       reg_rdata,
   input  logic [12:0]       evt_i,
   output logic              irq_o,
   output logic              core_rst_o,
   output logic              tx_rst_o,
   output logic              rx_rst_o
);
   localparam int unsigned NSIDE = 2;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W too small for the register offsets");
      end
      if (EVT_LSB + EVT_NUM != REG_W) begin : g_bad_evt
         $error("event field must end at the top bit");
      end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a == ADDR_W'(off);
   endfunction

   logic key_ok, go_core;
   logic [NSIDE-1:0] go_side, busy_side, last_side, done_side;
   logic [REG_W-1:0] set_vec, clr_vec, stat, ena;
   logic             irq_w, core_q;
   logic [REG_W-1:0] rdata_q;

   assign key_ok  = reg_wdata == RST_KEY;
   assign go_core = reg_we && hit(reg_waddr, OFF_CORE) && key_ok;
   assign go_side[SIDE_TX] = go_core || (reg_we && hit(reg_waddr, OFF_TXRST) && key_ok);
   assign go_side[SIDE_RX] = go_core || (reg_we && hit(reg_waddr, OFF_RXRST) && key_ok);

   genvar s;
   generate
      for (s = 0; s < NSIDE; s++) begin : g_side
         pirq_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .start (go_side[s]),
            .busy  (busy_side[s]),
            .last  (last_side[s])
         );
         assign done_side[s] = last_side[s] && !go_side[s];
      end
   endgenerate

   always_comb begin
      set_vec = '0;
      for (int k = 0; k < int'(EVT_NUM); k++) set_vec[EVT_LSB+k] = evt_i[k];
      set_vec[BIT_TX_RDY] = done_side[SIDE_TX];
      set_vec[BIT_RX_RDY] = done_side[SIDE_RX];
   end

   assign clr_vec = (reg_we && hit(reg_waddr, OFF_STAT)) ? (reg_wdata & IMPL_MASK) : '0;

   pirq_status #(.REG_W(REG_W), .MASK(IMPL_MASK)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .clr_vec   (clr_vec),
      .ena_we    (reg_we && hit(reg_waddr, OFF_ENA)),
      .ena_wdata (reg_wdata),
      .stat      (stat),
      .ena       (ena),
      .irq       (irq_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (go_core)             core_q <= 1'b1;
         else if (|done_side)     core_q <= 1'b0;
         if (reg_re) begin
            if (hit(reg_raddr, OFF_STAT))     rdata_q <= stat;
            else if (hit(reg_raddr, OFF_ENA)) rdata_q <= ena;
            else                              rdata_q <= '0;
         end
      end
   end

   assign reg_rdata  = rdata_q;
   assign irq_o      = irq_w;
   assign core_rst_o = core_q;
   assign tx_rst_o   = busy_side[SIDE_TX];
   assign rx_rst_o   = busy_side[SIDE_RX];

   assert_tx_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_rst_o) |-> stat[BIT_TX_RDY]);
   assert_rx_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_rst_o) |-> stat[BIT_RX_RDY]);
   assert_core_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o |-> (tx_rst_o || rx_rst_o));
   assert_read_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && hit(reg_raddr, OFF_STAT)) |=> (reg_rdata == $past(stat)));
   assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((stat & ena) != '0));
endmodule

// File: tb/pirq_ctrl_bench.sv
module pirq_ctrl_bench;
   localparam int N = 4;
   localparam logic [31:0] MASK = 32'hFFF8_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0, reg_re = 1'b0;
   logic [7:0] reg_waddr = '0, reg_raddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [12:0] evt_i = '0;
   logic irq_o, core_rst_o, tx_rst_o, rx_rst_o;

   int n_run = 0, n_fail = 0;
   logic [31:0] m_stat = '0, m_ena = '0;
   int tx_left = 0, rx_left = 0;
   logic m_core = 1'b0;

   always #10 clk = ~clk;

   pirq_ctrl #(.ADDR_W(8), .RST_CYCLES(N)) u_pirq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_raddr(reg_raddr),
      .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o),
      .core_rst_o(core_rst_o), .tx_rst_o(tx_rst_o), .rx_rst_o(rx_rst_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] evt_to_stat(input logic [12:0] e);
      logic [31:0] v = {e, 19'b0};
      v[24] = 1'b0;
      v[23] = 1'b0;
      return v;
   endfunction

   function automatic logic [31:0] read_model(input logic [7:0] a);
      if (a == 8'h00) return m_stat;
      if (a == 8'h04) return m_ena;
      return 32'h0;
   endfunction

   // one clock: drive at negedge, model, then check at the next negedge
   task automatic step(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                       input logic re, input logic [7:0] ra, input logic [12:0] ev,
                       input string req);
      logic [31:0] exp_rd, setv, clrv;
      logic core_go, tx_go, rx_go, tx_done, rx_done;
      reg_we = we; reg_waddr = wa; reg_wdata = wd;
      reg_re = re; reg_raddr = ra; evt_i = ev;
      exp_rd  = read_model(ra);
      core_go = we && wa == 8'h28 && wd == 32'hA5;
      tx_go   = core_go || (we && wa == 8'h08 && wd == 32'hA5);
      rx_go   = core_go || (we && wa == 8'h18 && wd == 32'hA5);
      tx_done = !tx_go && tx_left == 1;
      rx_done = !rx_go && rx_left == 1;
      if (tx_go) tx_left = N; else if (tx_left > 0) tx_left--;
      if (rx_go) rx_left = N; else if (rx_left > 0) rx_left--;
      if (core_go) m_core = 1'b1; else if (tx_done || rx_done) m_core = 1'b0;
      setv = evt_to_stat(ev);
      setv[24] = tx_done;
      setv[23] = rx_done;
      clrv = (we && wa == 8'h00) ? (wd & MASK) : 32'h0;
      m_stat = ((m_stat & ~clrv) | setv) & MASK;
      if (we && wa == 8'h04) m_ena = wd & MASK;
      @(negedge clk);
      reg_we = 1'b0; reg_re = 1'b0; evt_i = '0;
      if (re) check({req, " R11 read"}, reg_rdata, exp_rd);
      check({req, " R6 irq"}, {31'b0, irq_o}, {31'b0, |(m_stat & m_ena)});
      check({req, " R7 tx strobe"}, {31'b0, tx_rst_o}, {31'b0, tx_left > 0});
      check({req, " R7 rx strobe"}, {31'b0, rx_rst_o}, {31'b0, rx_left > 0});
      check({req, " R9 core"}, {31'b0, core_rst_o}, {31'b0, m_core});
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 13'h0, req);
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      step(1'b0, 8'h00, 32'h0, 1'b1, a, 13'h0, req);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
      step(1'b1, a, d, 1'b0, 8'h00, 13'h0, req);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      @(negedge clk); @(negedge clk);
      // R1 reset state
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      check("R1 strobes", {29'b0, core_rst_o, tx_rst_o, rx_rst_o}, 32'h0);
      check("R1 rdata", reg_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h00, "R1 stat");
      rd(8'h04, "R1 ena");

      // R2 all events with enable zero; R10 positions 24/23 ignored
      step(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 13'h1FFF, "R2");
      rd(8'h00, "R2 R10");
      check("R10 literal", reg_rdata, 32'hFE78_0000);
      check("R2 no irq when disabled", {31'b0, irq_o}, 32'h0);
      // R5 enable masked, R6 irq
      wr(8'h04, 32'hFFFF_FFFF, "R5");
      rd(8'h04, "R5");
      check("R5 literal", reg_rdata, 32'hFFF8_0000);
      check("R6 irq high", {31'b0, irq_o}, 32'h1);
      // R3 selective and full clear
      wr(8'h00, 32'h8000_0000, "R3 one bit");
      rd(8'h00, "R3");
      check("R3 literal", reg_rdata, 32'h7E78_0000);
      wr(8'h00, 32'hFFFF_FFFF, "R3 all");
      rd(8'h00, "R3");
      check("R3 cleared", reg_rdata, 32'h0);
      // R4 same-cycle set wins
      step(1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0, 8'h00, 13'h0100, "R4");
      rd(8'h00, "R4");
      check("R4 literal", reg_rdata, 32'h0800_0000);
      wr(8'h00, 32'hFFFF_FFFF, "R3");
      // R11 other offset
      rd(8'h0C, "R11 other");
      // R8 near-miss keys
      wr(8'h08, 32'h0000_01A5, "R8");
      wr(8'h18, 32'h0000_00A4, "R8");
      wr(8'h28, 32'hFF00_00A5, "R8");
      check("R8 no strobe", {29'b0, core_rst_o, tx_rst_o, rx_rst_o}, 32'h0);
      // R7 transmit, then receive
      wr(8'h08, 32'hA5, "R7 tx");
      idle(N + 1, "R7");
      rd(8'h00, "R7 tx");
      check("R7 tx bit", reg_rdata, 32'h0100_0000);
      wr(8'h18, 32'hA5, "R7 rx");
      idle(N + 1, "R7");
      rd(8'h00, "R7 rx");
      check("R7 rx bit", reg_rdata, 32'h0180_0000);
      wr(8'h00, 32'hFFFF_FFFF, "R3");
      // R9 core-wide
      wr(8'h28, 32'hA5, "R9");
      check("R9 both strobes", {29'b0, core_rst_o, tx_rst_o, rx_rst_o}, 32'h7);
      idle(N + 1, "R9");
      rd(8'h00, "R9");
      check("R9 bits", reg_rdata, 32'h0180_0000);
      wr(8'h00, 32'hFFFF_FFFF, "R3");
      // R12 restart on the last cycle
      wr(8'h08, 32'hA5, "R12");
      idle(N - 1, "R12");
      wr(8'h08, 32'hA5, "R12 restart");
      rd(8'h00, "R12 no early done");
      check("R12 literal", reg_rdata, 32'h0);
      idle(N + 1, "R12");
      rd(8'h00, "R12 done");
      check("R12 done literal", reg_rdata, 32'h0100_0000);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] pick;
         logic [7:0] wa, ra;
         logic [31:0] wd;
         pick = 3'($urandom_range(0, 7));
         case (pick)
            3'd0, 3'd1: wa = 8'h00;
            3'd2:       wa = 8'h04;
            3'd3:       wa = 8'h08;
            3'd4:       wa = 8'h18;
            3'd5:       wa = 8'h28;
            default:    wa = 8'h10;
         endcase
         wd = ($urandom_range(0, 5) == 0) ? 32'hA5 : $urandom();
         ra = ($urandom_range(0, 3) == 0) ? 8'h30 : {5'b0, 1'($urandom_range(0, 1)), 2'b00};
         step(1'($urandom_range(0, 1)), wa, wd, 1'($urandom_range(0, 1)), ra,
              13'($urandom()) & 13'($urandom()), "R2 random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule